// File: doc/BRIEF.md
# Local Descriptor Table Register Loader

This block loads the register that names the local descriptor table. A caller gives it a 16-bit selector, the base and limit of the global descriptor table, and a flag saying whether the load is part of a task switch. The block screens the selector, reads the 8-byte descriptor through a 32-bit memory read port, validates it, and then either commits the new register contents or reports a fault. The committed selector, base, limit and valid bit are driven out continuously, so that a segment loader can resolve local-table selectors against them.

A null global selector is a legal load that leaves the register invalid. Any fault leaves the previous contents untouched. The fault code is always the complete selector as supplied. The fault kind tells the caller which exception to raise.

The controller has five states. IDLE waits for `start_i`. RD_LO holds a read of the low descriptor word. RD_HI holds a read of the high descriptor word. EVAL checks the captured descriptor. FINISH raises `done_o` for one cycle. The transitions are as follows:
- IDLE goes to FINISH on start when the selector is refused or is null.
- IDLE goes to RD_LO on start when the selector passes screening.
- RD_LO goes to RD_HI on acknowledge.
- RD_HI goes to EVAL on acknowledge.
- EVAL goes to FINISH in every case.
- FINISH goes back to IDLE.

`start_i` is ignored outside IDLE.

Top module: `ldtr_loader`

## Requirements
- R1: After reset, `ldt_sel_o`, `ldt_base_o` and `ldt_limit_o` are zero, `ldt_valid_o` is 0, and `mem_req_o` and `done_o` are low.
- R2: A selector with bit 2 set is refused with the caller fault. No memory read is made, and `done_o` is high in the first cycle after the start edge.
- R3: A selector with bit 2 clear and bits 15:3 zero, whatever bits 1:0 hold, clears the stored selector, base and limit to zero and sets valid to 0. It ends without fault, with no memory read, one cycle after start.
- R4: When the selector offset (bits 15:3 with three zero bits below) plus 7 exceeds `gdt_limit_i`, the caller fault is raised without a memory read. An offset plus 7 equal to the limit is accepted.
- R5: A screened selector causes two reads in order. The low word is read at `gdt_base_i` + offset and the high word at that address + 4. Each request is held, with a stable address, until `mem_ack_i`.
- R6: The descriptor is accepted only when high-word bit 12 is 0 and high-word bits 11:8 equal 2. Any other descriptor, including the reserved system types, raises the caller fault.
- R7: A descriptor whose limit is below 7 raises the caller fault. The valid bit is never 1 with a stored limit below 7.
- R8: The present bit is high-word bit 15. When it is clear on an otherwise acceptable descriptor, the fault kind is 2 (task switch) if `task_switch_i` was set at start, and 3 (not present) otherwise.
- R9: On success, the base is {high[31:24], high[7:0], low[31:16]} and the limit is {high[19:16], low[15:0]}. High-word bit 23 is ignored, so no granularity scaling applies. The selector is stored unmasked and valid is set. With a memory that acknowledges at once, `done_o` comes four cycles after the start edge.
- R10: A fault leaves the stored selector, base, limit and valid bit unchanged.
- R11: Fault kinds are encoded as 0 none, 1 general, 2 task switch and 3 not present. The caller fault is kind 2 when `task_switch_i` was set at start, and kind 1 otherwise. `fault_code_o` equals the full selector. `done_o` is a one-cycle pulse, and `fault_o` is high only together with `done_o`.
- R12: Descriptor checks are prioritised as type first, then limit, then presence. A descriptor that has a wrong type and is also not present therefore reports the caller fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load; sampled in IDLE |
| sel_i | input | 16 | Selector to load |
| task_switch_i | input | 1 | Load is part of a task switch |
| gdt_base_i | input | 32 | Global table base address |
| gdt_limit_i | input | 16 | Global table limit |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Load faulted (with done) |
| fault_kind_o | output | 2 | Fault kind, encoded per R11 |
| fault_code_o | output | 16 | Fault error code (the selector) |
| ldt_sel_o | output | 16 | Stored selector |
| ldt_base_o | output | 32 | Cached table base |
| ldt_limit_o | output | 20 | Cached table limit |
| ldt_valid_o | output | 1 | Cached descriptor valid |

## Verification
A load refused at screening, or a null load, completes with `done_o` in the first cycle after the start edge. A load that reaches the descriptor completes four cycles after the start edge plus one cycle for every cycle an acknowledge is withheld. The stored register outputs change at the same edge that raises `done_o`. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from start until `done_o`, compares that count with the latency in each vector, and reads the fault and register outputs in that same done cycle. A memory model logs each acknowledged address, so that the read order and the absence of reads on early exits are checked at the port.

// File: rtl/ldtr_pkg.sv
package ldtr_pkg;

    // controller states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_LO  = 3'd1,
        ST_RD_HI  = 3'd2,
        ST_EVAL   = 3'd3,
        ST_FINISH = 3'd4
    } ldtr_state_e;

    // fault kinds reported with done
    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_GENERAL = 2'd1,
        FK_TASKSW  = 2'd2,
        FK_NOTPRES = 2'd3
    } ldtr_fault_e;

    // descriptor layout (high word bit positions)
    localparam int          DESC_W        = 32;
    localparam int          BASE_W        = 32;
    localparam int          LIMIT_W       = 20;
    localparam int          HI_PRESENT    = 15;
    localparam int          HI_SYSFLAG    = 12;
    localparam logic [3:0]  LDT_SYS_TYPE  = 4'd2;
    localparam int          MIN_LDT_LIMIT = 7;

    // fault kind used when the caller-selected fault applies
    function automatic ldtr_fault_e caller_kind(input logic ts);
        return ts ? FK_TASKSW : FK_GENERAL;
    endfunction

    // fault kind used when the descriptor is absent
    function automatic ldtr_fault_e absent_kind(input logic ts);
        return ts ? FK_TASKSW : FK_NOTPRES;
    endfunction

endpackage

// File: rtl/ldtr_sel_check.sv
module ldtr_sel_check #(
    parameter int SEL_W     = 16,
    parameter int GDT_LIM_W = 16
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [GDT_LIM_W-1:0] gdt_limit,
    output logic                 is_local,
    output logic                 is_null,
    output logic                 out_of_bounds
);
    localparam int CMP_W = ((SEL_W > GDT_LIM_W) ? SEL_W : GDT_LIM_W) + 1;

    logic [SEL_W-1:0] offset;
    logic [CMP_W-1:0] last_byte;
    logic             unused_rpl;

    always_comb begin
        offset        = {sel[SEL_W-1:3], 3'b000};
        is_local      = sel[2];
        is_null       = (sel[SEL_W-1:3] == '0);
        last_byte     = CMP_W'(offset) + CMP_W'(7);
        out_of_bounds = (last_byte > CMP_W'(gdt_limit));
    end

    assign unused_rpl = ^sel[1:0];

endmodule

// File: rtl/ldtr_desc_decode.sv
module ldtr_desc_decode
    import ldtr_pkg::*;
(
    input  logic [DESC_W-1:0]  lo_word,
    input  logic [DESC_W-1:0]  hi_word,
    output logic [BASE_W-1:0]  base,
    output logic [LIMIT_W-1:0] limit,
    output logic               present,
    output logic               type_ok,
    output logic               limit_ok
);
    logic unused_bits;

    always_comb begin
        base     = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        limit    = {hi_word[19:16], lo_word[15:0]};
        present  = hi_word[HI_PRESENT];
        type_ok  = !hi_word[HI_SYSFLAG] && (hi_word[11:8] == LDT_SYS_TYPE);
        limit_ok = (limit >= LIMIT_W'(MIN_LDT_LIMIT));
    end

    // granularity and privilege bits play no part for this descriptor
    assign unused_bits = ^{hi_word[23:20], hi_word[14:13]};

endmodule

// File: rtl/ldtr_cache.sv
module ldtr_cache
    import ldtr_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               clear,
    input  logic [SEL_W-1:0]   sel_in,
    input  logic [BASE_W-1:0]  base_in,
    input  logic [LIMIT_W-1:0] limit_in,
    output logic [SEL_W-1:0]   sel_out,
    output logic [BASE_W-1:0]  base_out,
    output logic [LIMIT_W-1:0] limit_out,
    output logic               valid_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_out   <= '0;
            base_out  <= '0;
            limit_out <= '0;
            valid_out <= 1'b0;
        end else if (clear) begin
            sel_out   <= '0;
            base_out  <= '0;
            limit_out <= '0;
            valid_out <= 1'b0;
        end else if (commit) begin
            sel_out   <= sel_in;
            base_out  <= base_in;
            limit_out <= limit_in;
            valid_out <= 1'b1;
        end
    end

endmodule

// File: rtl/ldtr_loader.sv
module ldtr_loader
    import ldtr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 16,
    parameter int GDT_LIM_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 task_switch_i,
    input  logic [ADDR_W-1:0]    gdt_base_i,
    input  logic [GDT_LIM_W-1:0] gdt_limit_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic                 mem_ack_i,
    input  logic [31:0]          mem_rdata_i,
    output logic                 done_o,
    output logic                 fault_o,
    output logic [1:0]           fault_kind_o,
    output logic [SEL_W-1:0]     fault_code_o,
    output logic [SEL_W-1:0]     ldt_sel_o,
    output logic [31:0]          ldt_base_o,
    output logic [19:0]          ldt_limit_o,
    output logic                 ldt_valid_o
);
    localparam logic [ADDR_W-1:0] HI_WORD_STEP = ADDR_W'(4);

    ldtr_state_e         state_q, state_d;
    logic [SEL_W-1:0]    sel_q;
    logic                ts_q;
    logic [DESC_W-1:0]   lo_q, hi_q;
    logic                fault_q;
    ldtr_fault_e         kind_q;

    // next-state decisions
    logic                to_finish;
    logic                fin_fault;
    ldtr_fault_e         fin_kind;
    logic                do_commit;
    logic                do_clear;

    // screening and decode results
    logic                sel_local, sel_null, sel_oob;
    logic [BASE_W-1:0]   dec_base;
    logic [LIMIT_W-1:0]  dec_limit;
    logic                dec_present, dec_type_ok, dec_limit_ok;
    logic [ADDR_W-1:0]   lo_addr;

    ldtr_sel_check #(
        .SEL_W     (SEL_W),
        .GDT_LIM_W (GDT_LIM_W)
    ) u_sel_check (
        .sel           (sel_i),
        .gdt_limit     (gdt_limit_i),
        .is_local      (sel_local),
        .is_null       (sel_null),
        .out_of_bounds (sel_oob)
    );

    ldtr_desc_decode u_decode (
        .lo_word  (lo_q),
        .hi_word  (hi_q),
        .base     (dec_base),
        .limit    (dec_limit),
        .present  (dec_present),
        .type_ok  (dec_type_ok),
        .limit_ok (dec_limit_ok)
    );

    ldtr_cache #(
        .SEL_W (SEL_W)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (do_commit),
        .clear     (do_clear),
        .sel_in    (sel_q),
        .base_in   (dec_base),
        .limit_in  (dec_limit),
        .sel_out   (ldt_sel_o),
        .base_out  (ldt_base_o),
        .limit_out (ldt_limit_o),
        .valid_out (ldt_valid_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and per-state decisions
    always_comb begin
        state_d   = state_q;
        to_finish = 1'b0;
        fin_fault = 1'b0;
        fin_kind  = FK_NONE;
        do_commit = 1'b0;
        do_clear  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (sel_local) begin
                        to_finish = 1'b1;
                        fin_fault = 1'b1;
                        fin_kind  = caller_kind(task_switch_i);
                    end else if (sel_null) begin
                        to_finish = 1'b1;
                        do_clear  = 1'b1;
                    end else if (sel_oob) begin
                        to_finish = 1'b1;
                        fin_fault = 1'b1;
                        fin_kind  = caller_kind(task_switch_i);
                    end else begin
                        state_d = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_ack_i) state_d = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (mem_ack_i) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                to_finish = 1'b1;
                if (!dec_type_ok) begin
                    fin_fault = 1'b1;
                    fin_kind  = caller_kind(ts_q);
                end else if (!dec_limit_ok) begin
                    fin_fault = 1'b1;
                    fin_kind  = caller_kind(ts_q);
                end else if (!dec_present) begin
                    fin_fault = 1'b1;
                    fin_kind  = absent_kind(ts_q);
                end else begin
                    do_commit = 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (to_finish) state_d = ST_FINISH;
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            ts_q    <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            fault_q <= 1'b0;
            kind_q  <= FK_NONE;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                sel_q <= sel_i;
                ts_q  <= task_switch_i;
            end
            if (state_q == ST_RD_LO && mem_ack_i) lo_q <= mem_rdata_i;
            if (state_q == ST_RD_HI && mem_ack_i) hi_q <= mem_rdata_i;
            if (to_finish) begin
                fault_q <= fin_fault;
                kind_q  <= fin_kind;
            end
        end
    end

    // outputs
    always_comb begin
        lo_addr      = gdt_base_i + ADDR_W'({sel_q[SEL_W-1:3], 3'b000});
        mem_req_o    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        mem_addr_o   = (state_q == ST_RD_HI) ? (lo_addr + HI_WORD_STEP) : lo_addr;
        done_o       = (state_q == ST_FINISH);
        fault_o      = done_o && fault_q;
        fault_kind_o = done_o ? kind_q : FK_NONE;
        fault_code_o = sel_q;
    end

endmodule

// File: rtl/ldtr_loader_chk.sv
module ldtr_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic        done_o,
    input logic        fault_o,
    input logic [15:0] ldt_sel_o,
    input logic [31:0] ldt_base_o,
    input logic [19:0] ldt_limit_o,
    input logic        ldt_valid_o
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fault_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);

    assert_hold_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> ($stable(ldt_sel_o) && $stable(ldt_base_o)
                                 && $stable(ldt_limit_o) && $stable(ldt_valid_o)));

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_valid_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ldt_valid_o |-> (ldt_limit_o >= 20'd7));

    assert_null_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && !ldt_valid_o) |->
            (ldt_sel_o == 16'd0 && ldt_base_o == 32'd0 && ldt_limit_o == 20'd0));

endmodule

bind ldtr_loader ldtr_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .ldt_sel_o   (ldt_sel_o),
    .ldt_base_o  (ldt_base_o),
    .ldt_limit_o (ldt_limit_o),
    .ldt_valid_o (ldt_valid_o)
);

// File: tb/ldtr_loader_test.sv
`timescale 1ns/1ps
module ldtr_loader_test;

    localparam logic [31:0] GDT_BASE = 32'h0000_1000;

    typedef struct packed {
        logic [15:0] sel;
        logic        ts;
        logic [1:0]  kind;
        logic        valid;
        logic [31:0] base;
        logic [19:0] lim;
        logic [3:0]  lat;
    } vec_t;

    // kind 0 = success; on success with valid 0 the register is cleared
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h0008, 1'b0, 2'd0, 1'b1, 32'h12345678, 20'h000FF, 4'd4},
        '{16'h0000, 1'b0, 2'd0, 1'b0, 32'h0,        20'h0,     4'd1},
        '{16'h000B, 1'b0, 2'd0, 1'b1, 32'h12345678, 20'h000FF, 4'd4},
        '{16'h0004, 1'b0, 2'd1, 1'b0, 32'h0,        20'h0,     4'd1},
        '{16'h0010, 1'b0, 2'd3, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0010, 1'b1, 2'd2, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0018, 1'b0, 2'd1, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0020, 1'b0, 2'd1, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0020, 1'b1, 2'd2, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0028, 1'b0, 2'd1, 1'b0, 32'h0,        20'h0,     4'd4},
        '{16'h0030, 1'b0, 2'd0, 1'b1, 32'hCA2DBEEF, 20'h00007, 4'd4},
        '{16'h0038, 1'b0, 2'd0, 1'b1, 32'h00ABCDEF, 20'h5FFFF, 4'd4},
        '{16'h0043, 1'b1, 2'd2, 1'b0, 32'h0,        20'h0,     4'd1},
        '{16'h000E, 1'b0, 2'd1, 1'b0, 32'h0,        20'h0,     4'd1},
        '{16'h0003, 1'b0, 2'd0, 1'b0, 32'h0,        20'h0,     4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sel = '0;
    logic        ts = 1'b0;
    logic [15:0] gdt_limit = 16'h003F;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        done, fault;
    logic [1:0]  fkind;
    logic [15:0] fcode, ldt_sel;
    logic [31:0] ldt_base;
    logic [19:0] ldt_limit;
    logic        ldt_valid;

    int passed = 0;
    int total  = 0;

    always #10 clk = ~clk;

    ldtr_loader uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .sel_i         (sel),
        .task_switch_i (ts),
        .gdt_base_i    (GDT_BASE),
        .gdt_limit_i   (gdt_limit),
        .mem_req_o     (mem_req),
        .mem_addr_o    (mem_addr),
        .mem_ack_i     (mem_ack),
        .mem_rdata_i   (mem_rdata),
        .done_o        (done),
        .fault_o       (fault),
        .fault_kind_o  (fkind),
        .fault_code_o  (fcode),
        .ldt_sel_o     (ldt_sel),
        .ldt_base_o    (ldt_base),
        .ldt_limit_o   (ldt_limit),
        .ldt_valid_o   (ldt_valid)
    );

    // global table contents, {high, low} per entry
    logic [63:0] gdt [8];
    initial begin
        gdt[0] = 64'h0;
        gdt[1] = {32'h12008234, 32'h567800FF};
        gdt[2] = {32'h12000234, 32'h567800FF};
        gdt[3] = {32'h12009234, 32'h567800FF};
        gdt[4] = {32'h12000934, 32'h567800FF};
        gdt[5] = {32'h12008234, 32'h56780005};
        gdt[6] = {32'hCA00822D, 32'hBEEF0007};
        gdt[7] = {32'h008582AB, 32'hCDEFFFFF};
    end

    // memory model with programmable wait
    logic [31:0] off;
    logic [3:0]  wait_cnt = '0;
    int          wait_load = 0;
    logic        log_clr = 1'b0;
    int          log_n = 0;
    logic [31:0] log_addr [4];

    always_comb begin
        off = mem_addr - GDT_BASE;
        if (off < 32'd64)
            mem_rdata = off[2] ? gdt[off[5:3]][63:32] : gdt[off[5:3]][31:0];
        else
            mem_rdata = 32'hDEADBEEF;
        mem_ack = mem_req && (wait_cnt == 4'd0);
    end

    always @(posedge clk) begin
        if (!mem_req || mem_ack) wait_cnt <= 4'(wait_load);
        else                     wait_cnt <= wait_cnt - 4'd1;
        if (log_clr) log_n <= 0;
        else if (mem_req && mem_ack) begin
            if (log_n < 4) log_addr[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    endtask

    // issue one load; returns cycles from start edge to done
    task automatic run(input logic [15:0] s, input logic t, output int lat);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1; sel = s; ts = t;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", passed, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    logic [15:0] e_sel = '0;
    logic [31:0] e_base = '0;
    logic [19:0] e_lim = '0;
    logic        e_valid = 1'b0;

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ldt_sel == 0 && ldt_base == 0 && ldt_limit == 0 && !ldt_valid, "R1 regs",
              {ldt_base, 12'h0, ldt_limit}, 64'h0);
        check(!mem_req && !done, "R1 ctrl", {mem_req, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run(v.sel, v.ts, lat);
            // R2 R3 R4 R9 latency
            check(lat == int'(v.lat), "R2/R3/R4/R9 latency", 64'(lat), 64'(v.lat));
            check(fault == (v.kind != 2'd0) && fkind == v.kind, "R6/R7/R8/R11/R12 kind",
                  {fault, fkind}, {(v.kind != 2'd0), v.kind});
            if (v.kind != 2'd0)
                check(fcode == v.sel, "R11 code", 64'(fcode), 64'(v.sel));
            else begin
                e_sel   = v.valid ? v.sel : 16'h0;
                e_base  = v.base;
                e_lim   = v.lim;
                e_valid = v.valid;
            end
            // R3 R9 R10 stored state
            check(ldt_sel == e_sel && ldt_base == e_base && ldt_limit == e_lim
                  && ldt_valid == e_valid, "R3/R9/R10 state",
                  {ldt_sel, ldt_base, ldt_limit[15:0]}, {e_sel, e_base, e_lim[15:0]});
            check(log_n == ((v.lat == 4'd1) ? 0 : 2), "R2/R4/R5 read count",
                  64'(log_n), (v.lat == 4'd1) ? 64'd0 : 64'd2);
            @(negedge clk);
            check(!done, "R11 pulse", 64'(done), 64'h0);
        end

        // R4 boundary: offset+7 one above a lowered limit
        gdt_limit = 16'h003E;
        run(16'h0038, 1'b0, lat);
        check(lat == 1 && fault && fkind == 2'd1, "R4 limit edge",
              {lat[7:0], fault, fkind}, {8'd1, 1'b1, 2'd1});
        check(ldt_base == e_base && ldt_valid == e_valid, "R10 hold after bound",
              {ldt_base, 31'h0, ldt_valid}, {e_base, 31'h0, e_valid});
        @(negedge clk);
        gdt_limit = 16'h003F;

        // R5 wait states and address order
        wait_load = 2;
        @(negedge clk);
        run(16'h0008, 1'b0, lat);
        check(lat == 8, "R5 wait latency", 64'(lat), 64'd8);
        check(log_n == 2 && log_addr[0] == GDT_BASE + 32'h8
              && log_addr[1] == GDT_BASE + 32'hC, "R5 address order",
              {log_addr[0], log_addr[1]}, {GDT_BASE + 32'h8, GDT_BASE + 32'hC});
        check(ldt_valid && ldt_base == 32'h12345678 && ldt_limit == 20'h000FF && ldt_sel == 16'h0008,
              "R9 commit after wait", {ldt_base, 12'h0, ldt_limit}, {32'h12345678, 32'h000FF});
        @(negedge clk);
        wait_load = 0;

        summary();
    end

endmodule